// File: doc/BRIEF.md
# SDRAM Single-Access Command Sequencer

This block turns one memory request into the timed SDRAM command stream for a single-beat read or write. A request carries the chip-select index, bank, row, column and, for writes, the data word. The sequencer opens the row with ACTIVE, waits out the row-to-column delay, and issues READ or WRITE. It then either lets the device close the row through the auto-precharge address bit or issues its own PRECHARGE, so that no row stays open between requests. For reads it marks the one clock in which the device drives data and forwards that word.

Timing comes from a five-bit configuration word held in a register inside the block. The word gives the row-to-column delay code, the CAS latency code and the auto-precharge flag. Software-side logic loads it with a one-clock strobe while the sequencer is idle. Refresh, power-up initialization, multi-beat bursts, device-organization address mapping and bus interfacing are handled elsewhere.

Top module: `sdram_cmd_sequencer`

## Requirements
- R1: After reset the configuration word is 5'b11111 (delay code 11, latency code 11, auto-precharge on), busy is 0, rd_valid is 0 and every chip select is high.
- R2: The clock after an idle sequencer samples req_valid high carries ACTIVE (cs low for the requested index only, RAS low, CAS high, WE high), with the row on sd_addr and the bank on sd_ba.
- R3: The column command comes tRCD clocks after ACTIVE. Configuration word bits [4:3] give tRCD: 10 gives 2 clocks and 11 gives 3 clocks. The column command puts the column on the low address bits and the auto-precharge flag (word bit 0) on sd_addr[10].
- R4: For every write, and for reads when the latency code is 01, tRCD is one clock longer than the coded value.
- R5: Word bits [2:1] set the CAS latency CL: 01 gives 1, 10 gives 2, 11 gives 3. rd_valid is high for exactly one clock, CL clocks after READ. In that clock rd_data equals sd_dq_in.
- R6: Delay codes 00 and 01 act as 3 clocks. Latency code 00 acts as latency 3.
- R7: Every clock of a sequence that carries no timed command drives NOP: the selected cs low and RAS, CAS and WE high.
- R8: With auto-precharge off, PRECHARGE (RAS low, CAS high, WE low, sd_addr[10] low, the request's bank) follows the write command or the read data clock on the next clock. With auto-precharge on, no PRECHARGE is issued.
- R9: busy is high from the ACTIVE clock through the last command or data clock. The sequencer returns to idle on the next clock. A request presented while busy is ignored.
- R10: A configuration load while busy is ignored. A load while idle takes effect from the next request.
- R11: For a write, sd_dq_oe is high and sd_dq_out carries the write data only in the WRITE clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_load | input | 1 | Load strobe for the configuration word |
| cfg_word | input | 5 | [4:3] delay code, [2:1] latency code, [0] auto-precharge |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cs | input | CS_IDX_W | Chip-select index |
| req_bank | input | BANK_W | Bank address |
| req_row | input | ROW_W | Row address |
| req_col | input | COL_W | Column address |
| req_wdata | input | DATA_W | Write data |
| busy | output | 1 | High while a sequence runs |
| rd_valid | output | 1 | Read data strobe |
| rd_data | output | DATA_W | Read data |
| sd_cs_n | output | NUM_CS | Chip selects, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BANK_W | Bank address |
| sd_addr | output | ADDR_W | Multiplexed address |
| sd_dq_out | output | DATA_W | Data toward the device |
| sd_dq_oe | output | 1 | Data output enable |
| sd_dq_in | input | DATA_W | Data from the device |

## Verification
The bench runs every timing code, including the reserved ones. It records the command on each clock of a sequence, so a delay that is one clock short or long, a missing +1 stretch for writes or latency-1 reads, or a reserved code decoded as the fastest setting shows up as a column command in the wrong clock. sd_dq_in carries a different value on every clock, so a strobe at the wrong latency returns a wrong word. It also checks that a PRECHARGE appears or stays absent according to the flag. A request and a configuration load are injected mid-sequence: a design that accepted either would run a second ACTIVE or change the timing of the following request.

// File: rtl/sdseq_pkg.sv
package sdseq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE, ST_ACT, ST_RCD, ST_COL, ST_LAT, ST_PRE
   } seq_state_t;

   typedef struct packed {
      logic [2:0] trcd;
      logic [2:0] tcl;
      logic       autopre;
   } timing_t;

   localparam logic [4:0] CFG_RESET = 5'b11111;

   function automatic timing_t decode_cfg(input logic [4:0] w);
      timing_t t;
      t.trcd    = (w[4:3] == 2'b10) ? 3'd2 : 3'd3;
      case (w[2:1])
         2'b01:   t.tcl = 3'd1;
         2'b10:   t.tcl = 3'd2;
         default: t.tcl = 3'd3;
      endcase
      t.autopre = w[0];
      return t;
   endfunction

endpackage

// File: rtl/sdseq_cfg.sv
module sdseq_cfg
   import sdseq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       load,
   input  logic [4:0] word,
   input  logic       busy,
   output timing_t    tim
);
   logic [4:0] raw_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            raw_q <= CFG_RESET;
      else if (load && !busy) raw_q <= word;
   end

   assign tim = decode_cfg(raw_q);

   assert_cfg_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(raw_q));
endmodule

// File: rtl/sdseq_timer.sv
module sdseq_timer #(
   parameter int CNT_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             dec,
   output logic             at_one
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt_q <= '0;
      else if (load)  cnt_q <= load_val;
      else if (dec)   cnt_q <= cnt_q - 1'b1;
   end

   assign at_one = (cnt_q == CNT_W'(1));

   assert_no_underflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (dec && !load) |-> (cnt_q > CNT_W'(1)));
endmodule

// File: rtl/sdram_cmd_sequencer.sv
module sdram_cmd_sequencer
   import sdseq_pkg::*;
#(
   parameter int NUM_CS   = 4,
   parameter int CS_IDX_W = $clog2(NUM_CS),
   parameter int BANK_W   = 2,
   parameter int ROW_W    = 13,
   parameter int COL_W    = 10,
   parameter int ADDR_W   = (ROW_W > 11) ? ROW_W : 11,
   parameter int DATA_W   = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_load,
   input  logic [4:0]          cfg_word,
   input  logic                req_valid,
   input  logic                req_write,
   input  logic [CS_IDX_W-1:0] req_cs,
   input  logic [BANK_W-1:0]   req_bank,
   input  logic [ROW_W-1:0]    req_row,
   input  logic [COL_W-1:0]    req_col,
   input  logic [DATA_W-1:0]   req_wdata,
   output logic                busy,
   output logic                rd_valid,
   output logic [DATA_W-1:0]   rd_data,
   output logic [NUM_CS-1:0]   sd_cs_n,
   output logic                sd_ras_n,
   output logic                sd_cas_n,
   output logic                sd_we_n,
   output logic [BANK_W-1:0]   sd_ba,
   output logic [ADDR_W-1:0]   sd_addr,
   output logic [DATA_W-1:0]   sd_dq_out,
   output logic                sd_dq_oe,
   input  logic [DATA_W-1:0]   sd_dq_in
);
   localparam int CNT_W  = 3;
   localparam int AP_BIT = 10;

   if (COL_W > AP_BIT) begin : g_bad_col
      $error("COL_W must leave address bit 10 free for auto-precharge");
   end
   if (ADDR_W < ROW_W || ADDR_W <= AP_BIT) begin : g_bad_addr
      $error("ADDR_W too narrow");
   end
   if (NUM_CS < 2 || (1 << CS_IDX_W) < NUM_CS) begin : g_bad_cs
      $error("NUM_CS / CS_IDX_W mismatch");
   end

   timing_t    tim;
   seq_state_t state_q, state_d;
   logic                wr_q;
   logic [CS_IDX_W-1:0] cs_q;
   logic [BANK_W-1:0]   bank_q;
   logic [ROW_W-1:0]    row_q;
   logic [COL_W-1:0]    col_q;
   logic [DATA_W-1:0]   wdata_q;
   logic                t_load, t_dec, t_one;
   logic [CNT_W-1:0]    t_val, trcd_eff;
   logic                accept;

   sdseq_cfg u_cfg (
      .clk(clk), .rst_n(rst_n), .load(cfg_load), .word(cfg_word),
      .busy(busy), .tim(tim)
   );

   sdseq_timer #(.CNT_W(CNT_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val),
      .dec(t_dec), .at_one(t_one)
   );

   assign busy     = (state_q != ST_IDLE);
   assign accept   = !busy && req_valid;
   assign trcd_eff = tim.trcd + CNT_W'(wr_q || (tim.tcl == 3'd1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         wr_q    <= 1'b0;
         cs_q    <= '0;
         bank_q  <= '0;
         row_q   <= '0;
         col_q   <= '0;
         wdata_q <= '0;
      end else begin
         state_q <= state_d;
         if (accept) begin
            wr_q    <= req_write;
            cs_q    <= req_cs;
            bank_q  <= req_bank;
            row_q   <= req_row;
            col_q   <= req_col;
            wdata_q <= req_wdata;
         end
      end
   end

   always_comb begin
      state_d = state_q;
      t_load  = 1'b0;
      t_dec   = 1'b0;
      t_val   = '0;
      unique case (state_q)
         ST_IDLE: if (req_valid) state_d = ST_ACT;
         ST_ACT: begin
            t_load  = 1'b1;
            t_val   = trcd_eff - 1'b1;
            state_d = ST_RCD;
         end
         ST_RCD: begin
            if (t_one) state_d = ST_COL;
            else       t_dec   = 1'b1;
         end
         ST_COL: begin
            if (wr_q) state_d = tim.autopre ? ST_IDLE : ST_PRE;
            else begin
               t_load  = 1'b1;
               t_val   = tim.tcl;
               state_d = ST_LAT;
            end
         end
         ST_LAT: begin
            if (t_one) state_d = tim.autopre ? ST_IDLE : ST_PRE;
            else       t_dec   = 1'b1;
         end
         ST_PRE:  state_d = ST_IDLE;
         default: state_d = ST_IDLE;
      endcase
   end

   for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
      assign sd_cs_n[g] = !(busy && (cs_q == CS_IDX_W'(g)));
   end

   always_comb begin
      sd_ras_n = 1'b1;
      sd_cas_n = 1'b1;
      sd_we_n  = 1'b1;
      sd_addr  = '0;
      unique case (state_q)
         ST_ACT: begin
            sd_ras_n = 1'b0;
            sd_addr[ROW_W-1:0] = row_q;
         end
         ST_COL: begin
            sd_cas_n = 1'b0;
            sd_we_n  = !wr_q;
            sd_addr[COL_W-1:0] = col_q;
            sd_addr[AP_BIT]    = tim.autopre;
         end
         ST_PRE: begin
            sd_ras_n = 1'b0;
            sd_we_n  = 1'b0;
         end
         default: ;
      endcase
   end

   assign sd_ba     = busy ? bank_q : '0;
   assign rd_valid  = (state_q == ST_LAT) && t_one;
   assign rd_data   = rd_valid ? sd_dq_in : '0;
   assign sd_dq_oe  = (state_q == ST_COL) && wr_q;
   assign sd_dq_out = sd_dq_oe ? wdata_q : '0;

   assert_cs_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~sd_cs_n));
   assert_idle_deselect_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (&sd_cs_n && !rd_valid && !sd_dq_oe));
   assert_pre_placement_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_PRE) |-> ($past(state_q) inside {ST_COL, ST_LAT} && !tim.autopre));
   assert_strobe_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |=> !rd_valid);
   assert_oe_on_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
      sd_dq_oe |-> (!sd_cas_n && !sd_we_n && sd_ras_n));
   assert_act_then_wait_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!sd_ras_n && sd_cas_n && sd_we_n) |=> (sd_ras_n && sd_cas_n && sd_we_n));
endmodule

// File: tb/sdram_cmd_sequencer_tb.sv
`timescale 1ns/1ps
module sdram_cmd_sequencer_tb_top;
   localparam int NUM_CS = 4, CS_IDX_W = 2, BANK_W = 2, ROW_W = 13,
                  COL_W = 10, ADDR_W = 13, DATA_W = 32;

   logic clk = 1'b0, rst_n = 1'b0;
   logic cfg_load = 1'b0;
   logic [4:0] cfg_word = '0;
   logic req_valid = 1'b0, req_write = 1'b0;
   logic [CS_IDX_W-1:0] req_cs = '0;
   logic [BANK_W-1:0] req_bank = '0;
   logic [ROW_W-1:0] req_row = '0;
   logic [COL_W-1:0] req_col = '0;
   logic [DATA_W-1:0] req_wdata = '0, sd_dq_in = '0;
   logic busy, rd_valid, sd_ras_n, sd_cas_n, sd_we_n, sd_dq_oe;
   logic [DATA_W-1:0] rd_data, sd_dq_out;
   logic [NUM_CS-1:0] sd_cs_n;
   logic [BANK_W-1:0] sd_ba;
   logic [ADDR_W-1:0] sd_addr;

   int n_cmp = 0, n_bad = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   sdram_cmd_sequencer dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_word(cfg_word),
      .req_valid(req_valid), .req_write(req_write), .req_cs(req_cs),
      .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
      .req_wdata(req_wdata), .busy(busy), .rd_valid(rd_valid), .rd_data(rd_data),
      .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
      .sd_ba(sd_ba), .sd_addr(sd_addr), .sd_dq_out(sd_dq_out), .sd_dq_oe(sd_dq_oe),
      .sd_dq_in(sd_dq_in)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic load_cfg(input logic [4:0] w);
      @(negedge clk);
      cfg_load = 1'b1; cfg_word = w;
      @(negedge clk);
      cfg_load = 1'b0;
   endtask

   // Runs one request and checks every clock against the expected schedule.
   // poke: inject a request and a config load one clock after ACTIVE.
   task automatic run_seq(input string tag, input bit wr, input int trcd,
                          input int cl, input bit ap, input int cs, input int bank,
                          input int row, input int col, input logic [31:0] wd,
                          input bit poke, input logic [4:0] poke_cfg);
      int last, fin;
      logic [31:0] base;
      base = 32'hA500_0000 + 32'(row);
      last = wr ? trcd : trcd + cl;
      fin  = ap ? last : last + 1;
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_cs = CS_IDX_W'(cs);
      req_bank = BANK_W'(bank); req_row = ROW_W'(row); req_col = COL_W'(col);
      req_wdata = wd;
      @(posedge clk); #1;
      req_valid = 1'b0;
      for (int k = 0; k <= fin + 2; k++) begin
         sd_dq_in = base + 32'(k);
         if (poke && k == 1) begin
            req_valid = 1'b1; req_row = ROW_W'(row + 1);
            cfg_load = 1'b1; cfg_word = poke_cfg;
         end
         @(negedge clk);
         if (k <= fin) begin
            chk(busy == 1'b1, "R9", {tag, " busy during sequence"}, busy, 1);
            chk(sd_cs_n == ~(4'(1) << cs), "R2", {tag, " chip select"}, sd_cs_n, ~(4'(1) << cs));
            chk(sd_ba == BANK_W'(bank), "R2", {tag, " bank"}, sd_ba, bank);
         end else begin
            chk(busy == 1'b0 && &sd_cs_n, "R9", {tag, " idle after sequence"}, {busy, sd_cs_n}, 5'h0f);
         end
         if (k == 0) begin
            chk({sd_ras_n, sd_cas_n, sd_we_n} == 3'b011, "R2", {tag, " ACTIVE"},
                {sd_ras_n, sd_cas_n, sd_we_n}, 3'b011);
            chk(sd_addr == ADDR_W'(row), "R2", {tag, " row"}, sd_addr, row);
         end else if (k == trcd) begin
            chk({sd_ras_n, sd_cas_n, sd_we_n} == {2'b10, !wr}, wr ? "R4" : "R3",
                {tag, " column command clock"}, {sd_ras_n, sd_cas_n, sd_we_n}, {2'b10, !wr});
            chk(sd_addr[9:0] == 10'(col) && sd_addr[10] == ap, "R3", {tag, " column address"},
                sd_addr, {ap, 10'(col)});
         end else if (k == fin && !ap) begin
            chk({sd_ras_n, sd_cas_n, sd_we_n} == 3'b010 && sd_addr[10] == 1'b0, "R8",
                {tag, " PRECHARGE"}, {sd_ras_n, sd_cas_n, sd_we_n, sd_addr[10]}, 4'b0100);
         end else begin
            chk({sd_ras_n, sd_cas_n, sd_we_n} == 3'b111, "R7", {tag, " NOP"},
                {sd_ras_n, sd_cas_n, sd_we_n}, 3'b111);
         end
         if (!wr && k == last) begin
            chk(rd_valid == 1'b1, "R5", {tag, " rd_valid at CL"}, rd_valid, 1);
            chk(rd_data == base + 32'(k), "R5", {tag, " rd_data"}, rd_data, base + 32'(k));
         end else begin
            chk(rd_valid == 1'b0, "R5", {tag, " rd_valid off"}, rd_valid, 0);
         end
         if (wr && k == trcd) begin
            chk(sd_dq_oe && sd_dq_out == wd, "R11", {tag, " write data"}, sd_dq_out, wd);
         end else begin
            chk(sd_dq_oe == 1'b0, "R11", {tag, " oe off"}, sd_dq_oe, 0);
         end
         @(posedge clk); #1;
         if (poke && k == 1) begin
            req_valid = 1'b0; cfg_load = 1'b0;
         end
      end
   endtask

   task automatic t_reset_r1;
      #1;
      chk(busy == 1'b0 && rd_valid == 1'b0 && &sd_cs_n, "R1", "reset outputs",
          {busy, rd_valid, sd_cs_n}, 6'h0f);
      run_seq("R1 default read", 0, 3, 3, 1, 2, 1, 100, 37, '0, 0, '0);
   endtask

   task automatic t_rcd2_noap_r3_r8;
      load_cfg(5'b10_10_0);
      run_seq("R3/R8 rcd2 cl2 read", 0, 2, 2, 0, 1, 3, 200, 5, '0, 0, '0);
      load_cfg(5'b11_11_0);
      run_seq("R3/R8 rcd3 cl3 read", 0, 3, 3, 0, 3, 2, 201, 1023, '0, 0, '0);
   endtask

   task automatic t_stretch_r4_r5;
      load_cfg(5'b10_01_1);
      run_seq("R4/R5 cl1 read", 0, 3, 1, 1, 0, 0, 300, 9, '0, 0, '0);
      load_cfg(5'b11_10_0);
      run_seq("R4/R11 write rcd3", 1, 4, 2, 0, 2, 1, 301, 17, 32'hCAFE_F00D, 0, '0);
      load_cfg(5'b10_11_1);
      run_seq("R4/R11 write rcd2 ap", 1, 3, 3, 1, 1, 2, 302, 64, 32'h1234_5678, 0, '0);
   endtask

   task automatic t_reserved_r6;
      load_cfg(5'b00_00_1);
      run_seq("R6 reserved 00/00", 0, 3, 3, 1, 0, 1, 400, 2, '0, 0, '0);
      load_cfg(5'b01_10_1);
      run_seq("R6 reserved 01", 0, 3, 2, 1, 3, 3, 401, 3, '0, 0, '0);
   endtask

   task automatic t_busy_ignore_r9_r10;
      load_cfg(5'b11_11_1);
      run_seq("R9/R10 busy poke", 0, 3, 3, 1, 1, 0, 500, 4, '0, 1, 5'b10_01_0);
      run_seq("R10 config kept", 0, 3, 3, 1, 2, 0, 502, 6, '0, 0, '0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset_r1();
      t_rcd2_noap_r3_r8();
      t_stretch_r4_r5();
      t_reserved_r6();
      t_busy_ignore_r9_r10();
      if (!finished) begin
         finished = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      #(200000 * 8);
      if (!finished) begin
         finished = 1;
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule